// File: doc/BRIEF.md
# Mode-Dependent Address Stepper

This block keeps the 13-bit location pointer of a byte-serial memory. The command front end supplies a start location with a load strobe. After that, it raises a one-cycle strobe each time a full 8-bit byte has moved across the serial link. On each strobe the pointer steps according to a 2-bit transfer mode. Reads and writes share the same stepping rule.

The memory is split into 32-byte pages. The upper address bits name the page and the low five bits give the byte within it. The modes behave as follows:

- **Page mode:** only the in-page offset counts, so the pointer loops around its own page.
- **Burst mode:** the whole pointer counts, so it loops around the full 8K space.
- **Single-byte mode:** the pointer does not move. The block instead raises a finished flag, which tells the surrounding logic to stop storing or driving bytes until the next command.

Top module: `xfer_addr_stepper`

## Requirements
- R1: While `rst_n` is sampled low on a clock edge, the block sets `addr_o` to 0 and clears `word_done_o`.
- R2: A cycle with `load_i` high sets `addr_o` to `load_addr_i` and clears `word_done_o` at the next edge.
- R3: When `load_i` and `byte_done_i` are high in the same cycle, the load wins. `addr_o` takes `load_addr_i`, no step is applied, and `word_done_o` is cleared.
- R4: In page mode (`mode_i` = 2'b10), a strobe without load adds one to `addr_o[4:0]` and leaves `addr_o[12:5]` unchanged. Offset 31 steps to offset 0 of the same page.
- R5: In burst mode (`mode_i` = 2'b01), a strobe without load adds one to the full 13-bit `addr_o`. 0x1FFF steps to 0x0000, and offset 31 carries into the next page.
- R6: In single-byte mode (`mode_i` = 2'b00), a strobe without load leaves `addr_o` unchanged and sets `word_done_o`. The flag stays high through later strobes until a load or a reset.
- R7: The reserved mode value 2'b11 behaves exactly like single-byte mode.
- R8: In a cycle with neither load nor strobe, `addr_o` and `word_done_o` hold. The pointer steps once for each cycle in which the strobe is high.
- R9: In page and burst modes, a strobe never sets `word_done_o`. After a load, the flag stays low for as long as those modes are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Load the pointer from `load_addr_i` |
| load_addr_i | input | 13 | Start location received with a command |
| byte_done_i | input | 1 | One completed byte transfer, one cycle per byte |
| mode_i | input | 2 | Transfer mode: 00 single, 10 page, 01 burst, 11 reserved (as single) |
| addr_o | output | 13 | Current pointer |
| word_done_o | output | 1 | Single-byte transfer finished |

## Verification
The properties treat each cycle with `byte_done_i` high as exactly one byte. They evaluate the mode input in that same cycle, so a mode change between bytes is legal. They also assume every input is a known value after reset.

The directed stimulus changes inputs only on the falling edge. It raises the strobe for single cycles or back-to-back runs, and it sets the mode before each strobe. Start locations are chosen next to page ends and next to the array end, so both wrap rules and the carry into the next page are reached.

// File: rtl/addr_step_pkg.sv
// Package: shared mode encoding for the address stepper.
// Assumes the mode value comes straight from a 2-bit configuration field.
package addr_step_pkg;
    typedef enum logic [1:0] {
        STEP_SINGLE = 2'b00,
        STEP_BURST  = 2'b01,
        STEP_PAGE   = 2'b10,
        STEP_RSVD   = 2'b11
    } step_mode_e;
endpackage

// File: rtl/step_mode_decode.sv
// Module: step_mode_decode
// Turns the 2-bit transfer mode into one-hot stepping selects.
// Assumes the reserved code must act as single-byte mode.
module step_mode_decode
    import addr_step_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       sel_page_o,
    output logic       sel_burst_o,
    output logic       sel_single_o
);
    // Decode the mode code into exactly one select.
    always_comb begin
        sel_page_o   = 1'b0;
        sel_burst_o  = 1'b0;
        sel_single_o = 1'b0;
        unique case (step_mode_e'(mode_i))
            STEP_PAGE:  sel_page_o   = 1'b1;
            STEP_BURST: sel_burst_o  = 1'b1;
            default:    sel_single_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/step_next_addr.sv
// Module: step_next_addr
// Computes the stepped pointer for page and burst modes.
// Assumes PAGE_W <= ADDR_W; when they are equal a page spans the whole array.
module step_next_addr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic              sel_page_i,
    output logic [ADDR_W-1:0] nxt_addr_o
);
    localparam int PAGE_HI = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] lin_step;
    logic [ADDR_W-1:0] page_step;

    // Linear step over the whole array; the carry out is dropped for the wrap.
    always_comb lin_step = cur_addr_i + ADDR_W'(1);

    generate
        if (PAGE_HI > 0) begin : g_paged
            // Step only the offset and keep the page index.
            always_comb page_step = {cur_addr_i[ADDR_W-1:PAGE_W],
                                     cur_addr_i[PAGE_W-1:0] + PAGE_W'(1)};
        end else begin : g_flat
            // One page covers the array, so page stepping is the linear step.
            always_comb page_step = lin_step;
        end
    endgenerate

    // Pick the wrap rule for the active mode.
    always_comb nxt_addr_o = sel_page_i ? page_step : lin_step;
endmodule

// File: rtl/step_ptr_reg.sv
// Module: step_ptr_reg
// Holds the pointer and the single-byte finished flag.
// Assumes load and step requests arrive as single-cycle qualifiers.
module step_ptr_reg #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              step_i,
    input  logic              finish_i,
    input  logic [ADDR_W-1:0] nxt_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);
    // Pointer register: reset, then load, then step, in that priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= load_addr_i;
        else if (step_i) addr_o <= nxt_addr_i;
    end

    // Finished flag: cleared by reset or load, set by a single-mode byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_o <= 1'b0;
        else if (load_i)   done_o <= 1'b0;
        else if (finish_i) done_o <= 1'b1;
    end
endmodule

// File: rtl/xfer_addr_stepper.sv
// Module: xfer_addr_stepper (top)
// Steps a byte-serial memory pointer once per transferred byte, by mode.
// Assumes byte_done_i pulses once per byte and mode_i is valid with it.
module xfer_addr_stepper #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              byte_done_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              word_done_o
);
    logic              sel_page;
    logic              sel_burst;
    logic              sel_single;
    logic [ADDR_W-1:0] nxt_addr;
    logic              step_req;
    logic              finish_req;

    step_mode_decode u_dec (
        .mode_i       (mode_i),
        .sel_page_o   (sel_page),
        .sel_burst_o  (sel_burst),
        .sel_single_o (sel_single)
    );

    step_next_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_nxt (
        .cur_addr_i (addr_o),
        .sel_page_i (sel_page),
        .nxt_addr_o (nxt_addr)
    );

    // Qualify the byte strobe by mode into a step request or a finish request.
    always_comb begin
        step_req   = byte_done_i & (sel_page | sel_burst);
        finish_req = byte_done_i & sel_single;
    end

    step_ptr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .step_i      (step_req),
        .finish_i    (finish_req),
        .nxt_addr_i  (nxt_addr),
        .addr_o      (addr_o),
        .done_o      (word_done_o)
    );
endmodule

// File: rtl/xfer_addr_stepper_chk.sv
// Module: xfer_addr_stepper_chk
// Property checker for the address stepper, bound to every instance.
// Assumes inputs are known after reset.
module xfer_addr_stepper_chk #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              byte_done_i,
    input logic [1:0]        mode_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              word_done_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_o == '0 && !word_done_o));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(load_addr_i) && !word_done_o));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && byte_done_i) |=> (addr_o == $past(load_addr_i)));

    // R4
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && mode_i == 2'b10) |=>
        (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]) &&
         addr_o[PAGE_W-1:0] == PAGE_W'($past(addr_o[PAGE_W-1:0]) + 1'b1)));

    // R5
    burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && mode_i == 2'b01) |=>
        (addr_o == ADDR_W'($past(addr_o) + 1'b1)));

    // R6
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && mode_i == 2'b00) |=>
        ($stable(addr_o) && word_done_o));

    // R7
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && mode_i == 2'b11) |=>
        ($stable(addr_o) && word_done_o));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !byte_done_i) |=> ($stable(addr_o) && $stable(word_done_o)));

    // R9
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && mode_i[1] != mode_i[0]) |=>
        (word_done_o == $past(word_done_o)));
endmodule

bind xfer_addr_stepper xfer_addr_stepper_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .load_addr_i (load_addr_i),
    .byte_done_i (byte_done_i),
    .mode_i      (mode_i),
    .addr_o      (addr_o),
    .word_done_o (word_done_o)
);

// File: tb/sim_xfer_addr_stepper.sv
// Directed bench for xfer_addr_stepper; inputs change on the falling edge.
module sim_xfer_addr_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [12:0] load_addr_i = '0;
    logic        byte_done_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [12:0] addr_o;
    logic        word_done_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    xfer_addr_stepper u0 (
        .clk (clk), .rst_n (rst_n), .load_i (load_i), .load_addr_i (load_addr_i),
        .byte_done_i (byte_done_i), .mode_i (mode_i),
        .addr_o (addr_o), .word_done_o (word_done_o)
    );

    always #2 clk = ~clk;

    // Compare one value and report a mismatch.
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock edge, then settle at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Load a start location with no strobe.
    task automatic do_load(input logic [12:0] a);
        load_i = 1'b1; load_addr_i = a; byte_done_i = 1'b0;
        tick();
        load_i = 1'b0;
    endtask

    // One byte strobe in the given mode.
    task automatic do_byte(input logic [1:0] m);
        mode_i = m; byte_done_i = 1'b1;
        tick();
        byte_done_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 addr", int'(addr_o), 0);
        chk("R1 flag", int'(word_done_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_load();
        do_load(13'h1234);
        chk("R2 addr", int'(addr_o), 'h1234);
        chk("R2 flag", int'(word_done_o), 0);
    endtask

    task automatic t_page();
        do_load(13'h0A3D);
        do_byte(2'b10); chk("R4 step", int'(addr_o), 'h0A3E);
        do_byte(2'b10); chk("R4 step31", int'(addr_o), 'h0A3F);
        do_byte(2'b10); chk("R4 wrap", int'(addr_o), 'h0A20);
        chk("R9 page flag", int'(word_done_o), 0);
        // 32 back-to-back strobes return to the same spot
        mode_i = 2'b10; byte_done_i = 1'b1;
        for (int i = 0; i < 32; i++) tick();
        byte_done_i = 1'b0;
        chk("R4 loop", int'(addr_o), 'h0A20);
    endtask

    task automatic t_burst();
        do_load(13'h003F);
        do_byte(2'b01); chk("R5 page carry", int'(addr_o), 'h0040);
        do_load(13'h1FFE);
        do_byte(2'b01); chk("R5 top", int'(addr_o), 'h1FFF);
        do_byte(2'b01); chk("R5 wrap", int'(addr_o), 'h0000);
        do_byte(2'b01); chk("R5 after", int'(addr_o), 'h0001);
        chk("R9 burst flag", int'(word_done_o), 0);
    endtask

    task automatic t_single(input logic [1:0] m, input string tag);
        do_load(13'h0100);
        chk({tag, " pre flag"}, int'(word_done_o), 0);
        do_byte(m);
        chk({tag, " addr"}, int'(addr_o), 'h0100);
        chk({tag, " flag"}, int'(word_done_o), 1);
        do_byte(m);
        chk({tag, " addr again"}, int'(addr_o), 'h0100);
        chk({tag, " flag held"}, int'(word_done_o), 1);
        do_load(13'h0200);
        chk({tag, " flag clear"}, int'(word_done_o), 0);
    endtask

    task automatic t_priority();
        do_load(13'h0500);
        mode_i = 2'b01; load_i = 1'b1; load_addr_i = 13'h0777; byte_done_i = 1'b1;
        tick();
        load_i = 1'b0; byte_done_i = 1'b0;
        chk("R3 burst", int'(addr_o), 'h0777);
        do_byte(2'b00);
        mode_i = 2'b00; load_i = 1'b1; load_addr_i = 13'h0033; byte_done_i = 1'b1;
        tick();
        load_i = 1'b0; byte_done_i = 1'b0;
        chk("R3 single addr", int'(addr_o), 'h0033);
        chk("R3 single flag", int'(word_done_o), 0);
    endtask

    task automatic t_idle();
        do_load(13'h0010);
        mode_i = 2'b01;
        for (int i = 0; i < 5; i++) tick();
        chk("R8 idle", int'(addr_o), 'h0010);
        byte_done_i = 1'b1;
        for (int i = 0; i < 3; i++) tick();
        byte_done_i = 1'b0;
        tick();
        chk("R8 three steps", int'(addr_o), 'h0013);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_page();
        t_burst();
        t_single(2'b00, "R6");
        t_single(2'b11, "R7");
        t_priority();
        t_idle();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule